// File: doc/BRIEF.md
# Glitch-free clock switch

This block takes two free-running clocks that have no phase or frequency relation to each other. A single select line chooses which of them drives the output clock. A change of the select never produces a shortened pulse on the output. Each input passes through its own gate. A gate that is closed holds its branch at logic high, and the two branches are combined by an AND. The output therefore shows the live clock while one gate is open, and a steady high level while both are closed.

Each clock domain has its own small controller. The controller brings the select into its domain through a synchronizer and decides whether its gate should be open. It closes the gate only on a rising edge of its own clock. It opens the gate only after it has seen, through a second synchronizer, that the other domain's gate is closed. The result is break-before-make. During a switch the old clock is parked high first, the output stays high for the gap, and the new clock is then let through starting from one of its own high phases.

The select input may change at any time, but it must then stay stable until the switch has completed. After reset, clock A drives the output and clock B is parked.

Top module: `clk_park_switch`

## Requirements
- R1: While `rstN` is low, the output follows `clkA`. Gate A is open and gate B is closed (parked high).
- R2: With `selB` = 0 held steady, once the switch has completed the output equals `clkA`.
- R3: With `selB` = 1 held steady, once the switch has completed the output equals `clkB`.
- R4: No high pulse on the output is shorter than the shortest high phase of the two inputs, including the pulses around a switch.
- R5: No low pulse on the output is shorter than the shortest low phase of the two inputs.
- R6: A gate closes or opens only on a rising edge of its own clock, so its flag changes only while that clock is high.
- R7: The two gates are never open at the same time. A gate opens only while the other gate is closed.
- R8: Between the closing of one gate and the opening of the other, the output is held high. Every falling edge of the output coincides with a falling edge of the input whose gate is open.
- R9: With `SYNC_STAGES` synchronizer flops, a switch completes within (`SYNC_STAGES`+2) periods of the old clock plus (`SYNC_STAGES`+2) periods of the new clock. The select must be held for at least that long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | First free-running clock, selected when `selB` is 0 |
| clkB | input | 1 | Second free-running clock, selected when `selB` is 1 |
| rstN | input | 1 | Active-low asynchronous reset of both domain controllers |
| selB | input | 1 | Asynchronous select: 0 chooses `clkA`, 1 chooses `clkB` |
| clkOut | output | 1 | Switched output clock |

## Verification
A gate flag that is wrongly stuck closed shows at the port as an output that stays high. The bench sees this at the first follow check after the R9 window, at most a few periods of the slower clock after the select changed. A gate that is wrongly open together with the other lets the AND of both clocks through. That produces high pulses narrower than either input's high phase, which the pulse-width monitor reports at the next falling edge of the output. A gate that changes while its clock is low cuts a high phase short, which the same monitor reports on that pulse. A falling edge of the output that matches no input fall is reported at the moment it occurs.

// File: rtl/clk_park_pkg.sv
`timescale 1ns/1ps
package clk_park_pkg;

  // Gate control passed from the domain controllers to the gating datapath.
  // A set flag closes that input's gate and holds its branch high.
  typedef struct packed {
    logic parkA;
    logic parkB;
  } parkStrobes_t;

  localparam int NumInputs = 2;

endpackage

// File: rtl/clk_park_domain.sv
`timescale 1ns/1ps
// Controller for one clock domain. It brings in the select and the peer's
// park flag through synchronizers and updates its own park flag only on a
// rising edge of its own clock.
module clk_park_domain #(
  parameter int SYNC_STAGES   = 2,
  parameter bit MY_SEL        = 1'b0,
  parameter bit PARK_AT_RESET = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic selAsync,
  input  logic otherPark,
  output logic park
);

  localparam int Msb = SYNC_STAGES - 1;

  logic [Msb:0] selPipe;
  logic [Msb:0] peerPipe;
  logic         wantRun;
  logic         peerParked;

  // The peer starts parked exactly when this domain starts running.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPipe  <= '0;
      peerPipe <= {SYNC_STAGES{~PARK_AT_RESET}};
    end else begin
      selPipe  <= {selPipe[Msb-1:0], selAsync};
      peerPipe <= {peerPipe[Msb-1:0], otherPark};
    end
  end

  assign wantRun    = (selPipe[Msb] == MY_SEL);
  assign peerParked = peerPipe[Msb];

  // Close at once when deselected. Open only when selected and the peer is
  // confirmed parked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) park <= PARK_AT_RESET;
    else       park <= ~(wantRun & peerParked);
  end

endmodule

// File: rtl/clk_park_ctrl.sv
`timescale 1ns/1ps
// Control side: one domain controller per input clock, cross-coupled
// through their park flags.
module clk_park_ctrl
  import clk_park_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clkA,
  input  logic         clkB,
  input  logic         rstN,
  input  logic         selB,
  output parkStrobes_t strobes
);

  logic [NumInputs-1:0] clkVec;
  logic [NumInputs-1:0] parkVec;

  assign clkVec = {clkB, clkA};

  for (genvar d = 0; d < NumInputs; d++) begin : g_dom
    clk_park_domain #(
      .SYNC_STAGES  (SYNC_STAGES),
      .MY_SEL       (d == 1),
      .PARK_AT_RESET(d == 1)
    ) u_dom (
      .clk      (clkVec[d]),
      .rstN     (rstN),
      .selAsync (selB),
      .otherPark(parkVec[NumInputs-1-d]),
      .park     (parkVec[d])
    );
  end

  assign strobes.parkA = parkVec[0];
  assign strobes.parkB = parkVec[1];

endmodule

// File: rtl/clk_park_gate.sv
`timescale 1ns/1ps
// Datapath: each clock is ORed with its park flag, and the branches are ANDed.
module clk_park_gate
  import clk_park_pkg::*;
(
  input  logic         clkA,
  input  logic         clkB,
  input  parkStrobes_t strobes,
  output logic         clkOut
);

  logic [NumInputs-1:0] clkVec;
  logic [NumInputs-1:0] parkVec;
  logic [NumInputs-1:0] gated;

  assign clkVec  = {clkB, clkA};
  assign parkVec = {strobes.parkB, strobes.parkA};

  for (genvar d = 0; d < NumInputs; d++) begin : g_or
    assign gated[d] = clkVec[d] | parkVec[d];
  end

  assign clkOut = &gated;

endmodule

// File: rtl/clk_park_switch.sv
`timescale 1ns/1ps
// Top: glitch-free switch between two asynchronous clocks.
module clk_park_switch
  import clk_park_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkA,
  input  logic clkB,
  input  logic rstN,
  input  logic selB,
  output logic clkOut
);

  parkStrobes_t strobes;

  clk_park_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clkA   (clkA),
    .clkB   (clkB),
    .rstN   (rstN),
    .selB   (selB),
    .strobes(strobes)
  );

  clk_park_gate u_gate (
    .clkA   (clkA),
    .clkB   (clkB),
    .strobes(strobes),
    .clkOut (clkOut)
  );

endmodule

// File: rtl/clk_park_switch_chk.sv
`timescale 1ns/1ps
module clk_park_switch_chk (
  input logic clkA,
  input logic clkB,
  input logic rstN,
  input logic clkOut,
  input logic parkA,
  input logic parkB
);

  // R1
  reset_state_chk: assert property (@(posedge clkA)
    !rstN |-> (!parkA && parkB));

  // R7
  exclusive_a_chk: assert property (@(posedge clkA) disable iff (!rstN)
    parkA || parkB);

  // R7
  exclusive_b_chk: assert property (@(posedge clkB) disable iff (!rstN)
    parkA || parkB);

  // R7
  open_a_after_b_chk: assert property (@(posedge clkA) disable iff (!rstN)
    $fell(parkA) |-> parkB);

  // R7
  open_b_after_a_chk: assert property (@(posedge clkB) disable iff (!rstN)
    $fell(parkB) |-> parkA);

  // R8
  gap_high_chk: assert property (@(posedge clkB) disable iff (!rstN)
    (parkA && parkB) |-> clkOut);

  // R6
  always @(parkA) begin
    if (rstN === 1'b1) begin
      park_a_edge_chk: assert (clkA === 1'b1);
    end
  end

  // R6
  always @(parkB) begin
    if (rstN === 1'b1) begin
      park_b_edge_chk: assert (clkB === 1'b1);
    end
  end

endmodule

bind clk_park_switch clk_park_switch_chk u_chk (
  .clkA  (clkA),
  .clkB  (clkB),
  .rstN  (rstN),
  .clkOut(clkOut),
  .parkA (strobes.parkA),
  .parkB (strobes.parkB)
);

// File: tb/clk_park_switch_test.sv
`timescale 1ns/1ps
module clk_park_switch_test;

  localparam int SyncStages = 2;
  localparam int PeriodA    = 10;          // 100 MHz, 5 high / 5 low
  localparam int HighB      = 9;
  localparam int LowB       = 8;
  localparam int PeriodB    = HighB + LowB;
  localparam int StartB     = 3;           // first rise of clkB
  localparam int MinHigh    = 5;
  localparam int MinLow     = 5;
  localparam int SwitchWait = (SyncStages + 2) * (PeriodA + PeriodB) + 2;

  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic rstN = 1'b0;
  logic selB = 1'b0;
  logic clkOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  clk_park_switch #(.SYNC_STAGES(SyncStages)) uut (
    .clkA  (clkA),
    .clkB  (clkB),
    .rstN  (rstN),
    .selB  (selB),
    .clkOut(clkOut)
  );

  initial forever #(PeriodA / 2) clkA = ~clkA;

  initial begin
    #(StartB);
    forever begin
      clkB = 1'b1; #(HighB);
      clkB = 1'b0; #(LowB);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic followA(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(posedge clkA); #1;
      check(clkOut === 1'b1, tag, int'(clkOut), 1);
      @(negedge clkA); #1;
      check(clkOut === 1'b0, tag, int'(clkOut), 0);
    end
  endtask

  task automatic followB(input string tag);
    for (int i = 0; i < 4; i++) begin
      @(posedge clkB); #1;
      check(clkOut === 1'b1, tag, int'(clkOut), 1);
      @(negedge clkB); #1;
      check(clkOut === 1'b0, tag, int'(clkOut), 0);
    end
  endtask

  // Pulse-width and falling-edge monitor, active after the first edges.
  bit      monOn   = 1'b0;
  bit      started = 1'b0;
  realtime lastEdge;

  always @(clkOut) begin
    if (monOn) begin
      if (started) begin
        if (clkOut === 1'b0) begin
          // high pulse just ended: a shortened one means a gate moved while
          // its clock was low, or both gates were open
          check(($realtime - lastEdge) >= MinHigh, "R4/R6/R7 high width",
                int'(($realtime - lastEdge) * 1000), MinHigh * 1000);
        end else begin
          check(($realtime - lastEdge) >= MinLow, "R5 low width",
                int'(($realtime - lastEdge) * 1000), MinLow * 1000);
        end
      end
      if (clkOut === 1'b0) begin
        // R8: output falls only together with a fall of an input clock
        int t;
        bit aFall;
        bit bFall;
        t     = int'($realtime);
        aFall = ($realtime == t) && (t % PeriodA == 0);
        bFall = ($realtime == t) && (t >= StartB + HighB) &&
                ((t - StartB - HighB) % PeriodB == 0);
        check(aFall || bFall, "R8 fall alignment", t, 0);
      end
      started  = 1'b1;
      lastEdge = $realtime;
    end
  end

  initial begin
    #(2 * PeriodB);
    monOn = 1'b1;
  end

  initial begin
    #1;
    // R1: output follows clkA while reset is held
    followA("R1 reset");
    #3;
    rstN = 1'b1;
    followA("R1/R2 after reset");

    for (int off = 0; off < PeriodB; off++) begin
      @(posedge clkA); #(off);
      selB = 1'b1;
      #(SwitchWait);
      followB("R3/R9 to B");
      @(posedge clkB); #(off);
      selB = 1'b0;
      #(SwitchWait);
      followA("R2/R9 to A");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule